// File: doc/BRIEF.md
# Key Input Interrupt Detector

This block watches a bank of ten key lines and turns key activity into one interrupt. Each line is brought into the clock domain through two flops. One global bit sets which edge counts: falling or rising. The inactive level of every line is the opposite of that edge's end level. An enable mask picks which lines take part at all.

The block runs in one of two modes. In combined mode, every enabled line feeds a single idle term through its level. The interrupt fires once when that term stops being "all idle". In flag mode, the six low lines each own a sticky flag that is set by a valid edge, and those lines then count through their flag, not their level. The four upper lines have no flag and still count only through their level. So a short press on an upper line can be lost while a flag is still pending. A flag-clear write that leaves the term not idle raises the interrupt again one clock later.

A small write port holds the edge bit, the mode bit and the enable mask. The same port takes the write-one-to-clear flag clears and the clear of the sticky request. The block drives a one-cycle interrupt pulse, a sticky request bit and the flag vector.

Top module: `key_irq_detect`

## Requirements
- R1: After reset, the pulse, the request and all flags are 0. The edge bit, the mode bit and every enable bit are also 0.
- R2: Edge bit 0 makes a high-to-low change the valid edge on every line. Edge bit 1 makes a low-to-high change the valid edge. The inactive level is high for bit 0 and low for bit 1.
- R3: The combined term is idle when every enabled line is idle. In either mode, an upper line (6–9) is idle when it sits at its inactive level. A low line (0–5) is idle when it sits at its inactive level in combined mode, and when its flag is clear in flag mode. When the term leaves idle, irq_pulse is high for exactly one cycle. In combined mode this happens on the third rising clock edge after the line changes.
- R4: In flag mode, a valid edge on an enabled line 0–5 sets that line's flag. The flag stays set after the line returns to its inactive level. It does not raise a second pulse while the term is already not idle.
- R5: A write to address 2 clears flag i for every data bit i written as 1. When a clear and a setting edge reach the same flag in the same cycle, the clear wins.
- R6: In flag mode, a flag-clear write that leaves the combined term not idle gives irq_pulse on the second rising edge after the write is sampled, that is, one clock after the flags change. If the term is idle after the clear, no pulse follows.
- R7: In flag mode, a valid edge on line 6–9 gives no pulse if the line returns to its inactive level before the pending flags are cleared.
- R8: A line whose enable bit is 0 gives no pulse and sets no flag. Clearing the enable bit of a set flag forces that flag to 0 on the next edge.
- R9: In combined mode, all flags stay 0.
- R10: irq_pending goes high the cycle after irq_pulse. It clears on irq_ack or on any write to address 3. A new pulse wins over a clear in the same cycle.
- R11: Register map: address 0 holds the edge bit in data bit 0 and the mode bit in data bit 1 (1 selects flag mode). Address 1 holds the enable mask, with bit i for line i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_in | input | 10 | Raw key lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 10 | Register write data |
| irq_ack | input | 1 | Interrupt acknowledge, clears the request |
| irq_pulse | output | 1 | One-cycle interrupt pulse |
| irq_pending | output | 1 | Sticky interrupt request |
| key_flags | output | 6 | Sticky flags of lines 0–5 |

## Verification
A line change made between edges reaches the synchronized level after two rising edges. In combined mode the pulse is then due on the third edge. In flag mode the flag is set on the third edge and the pulse follows on the fourth. A flag clear or a register write acts on the edge that samples it. The pulse it re-raises comes one edge later, and the request rises one edge after any pulse. The bench model steps through these same stages once per rising edge and compares all outputs at every falling edge. Directed checks sample the pulse exactly on the edge where it is due.

// File: rtl/kirq_pkg.sv
package kirq_pkg;

  typedef enum logic [1:0] {
    REG_CTRL     = 2'd0,
    REG_ENABLE   = 2'd1,
    REG_FLAG_CLR = 2'd2,
    REG_IRQ_CLR  = 2'd3
  } kirq_reg_e;

  // level at the active end of the selected edge
  function automatic logic level_is_active(input logic lvl, input logic rise);
    return rise ? lvl : ~lvl;
  endfunction

  // valid transition from prev to cur for the selected edge
  function automatic logic edge_seen(input logic prev, input logic cur, input logic rise);
    return rise ? (~prev & cur) : (prev & ~cur);
  endfunction

endpackage

// File: rtl/kirq_sync.sv
module kirq_sync #(
  parameter int   W       = 10,
  parameter logic RST_LVL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] lvl,
  output logic [W-1:0] prev
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= {W{RST_LVL}};
      lvl  <= {W{RST_LVL}};
      prev <= {W{RST_LVL}};
    end else begin
      meta <= din;
      lvl  <= meta;
      prev <= lvl;
    end
  end
endmodule

// File: rtl/kirq_flag_bank.sv
module kirq_flag_bank #(
  parameter int NF = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_mode,
  input  logic [NF-1:0] en,
  input  logic [NF-1:0] set_vec,
  input  logic [NF-1:0] clr_vec,
  output logic [NF-1:0] flags
);
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)
        flags[g] <= 1'b0;
      else if (!flag_mode || !en[g] || clr_vec[g])
        flags[g] <= 1'b0;
      else if (set_vec[g])
        flags[g] <= 1'b1;
    end
  end
endmodule

// File: rtl/kirq_combine.sv
module kirq_combine #(
  parameter int NK = 10,
  parameter int NF = 6
) (
  input  logic [NK-1:0] act,
  input  logic [NK-1:0] en,
  input  logic [NF-1:0] flags,
  input  logic          flag_mode,
  output logic          all_idle
);
  logic [NK-1:0] busy;

  for (genvar g = 0; g < NK; g++) begin : g_term
    if (g < NF) begin : g_flagged
      assign busy[g] = en[g] & (flag_mode ? flags[g] : act[g]);
    end else begin : g_plain
      assign busy[g] = en[g] & act[g];
    end
  end

  assign all_idle = ~|busy;
endmodule

// File: rtl/key_irq_detect.sv
module key_irq_detect
  import kirq_pkg::*;
#(
  parameter int N_KEYS  = 10,
  parameter int N_FLAGS = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_KEYS-1:0]  key_in,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [N_KEYS-1:0]  wr_data,
  input  logic               irq_ack,
  output logic               irq_pulse,
  output logic               irq_pending,
  output logic [N_FLAGS-1:0] key_flags
);
  // configuration
  logic              cfg_rise;
  logic              cfg_mode;
  logic [N_KEYS-1:0] cfg_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_rise <= 1'b0;
      cfg_mode <= 1'b0;
      cfg_en   <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        REG_CTRL:   {cfg_mode, cfg_rise} <= wr_data[1:0];
        REG_ENABLE: cfg_en <= wr_data;
        default: ;
      endcase
    end
  end

  // named write events
  logic               clr_write;
  logic               irq_clr_write;
  logic [N_FLAGS-1:0] clr_bits;

  assign clr_write     = wr_en && (wr_addr == REG_FLAG_CLR);
  assign irq_clr_write = wr_en && (wr_addr == REG_IRQ_CLR);
  assign clr_bits      = wr_data[N_FLAGS-1:0] & {N_FLAGS{clr_write}};

  // synchronized lines
  logic [N_KEYS-1:0] key_lvl;
  logic [N_KEYS-1:0] key_prev;

  kirq_sync #(.W(N_KEYS), .RST_LVL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (key_in),
    .lvl  (key_lvl),
    .prev (key_prev)
  );

  logic [N_KEYS-1:0]  act_vec;
  logic [N_FLAGS-1:0] edge_vec;

  for (genvar g = 0; g < N_KEYS; g++) begin : g_act
    assign act_vec[g] = level_is_active(key_lvl[g], cfg_rise);
  end
  for (genvar g = 0; g < N_FLAGS; g++) begin : g_edge
    assign edge_vec[g] = edge_seen(key_prev[g], key_lvl[g], cfg_rise);
  end

  kirq_flag_bank #(.NF(N_FLAGS)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_mode(cfg_mode),
    .en       (cfg_en[N_FLAGS-1:0]),
    .set_vec  (edge_vec),
    .clr_vec  (clr_bits),
    .flags    (key_flags)
  );

  logic all_idle;

  kirq_combine #(.NK(N_KEYS), .NF(N_FLAGS)) u_comb (
    .act      (act_vec),
    .en       (cfg_en),
    .flags    (key_flags),
    .flag_mode(cfg_mode),
    .all_idle (all_idle)
  );

  // interrupt generation
  logic idle_q;
  logic clr_q;
  logic leave_idle;
  logic reassert;

  assign leave_idle = idle_q & ~all_idle;
  assign reassert   = clr_q & ~all_idle;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q      <= 1'b1;
      clr_q       <= 1'b0;
      irq_pulse   <= 1'b0;
      irq_pending <= 1'b0;
    end else begin
      idle_q      <= all_idle;
      clr_q       <= clr_write & cfg_mode;
      irq_pulse   <= leave_idle | reassert;
      irq_pending <= irq_pulse | (irq_pending & ~(irq_ack | irq_clr_write));
    end
  end
endmodule

// File: rtl/kirq_checker.sv
module kirq_checker #(
  parameter int NF = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq_pulse,
  input logic          irq_pending,
  input logic [NF-1:0] key_flags,
  input logic          all_idle,
  input logic          clr_q,
  input logic          clr_write,
  input logic [NF-1:0] clr_bits,
  input logic          cfg_mode,
  input logic [NF-1:0] en_lo,
  input logic          irq_ack
);
  assert_pulse_needs_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(!all_idle));

  assert_clear_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_write |=> ((key_flags & $past(clr_bits)) == '0));

  assert_reraise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_q && !all_idle) |=> irq_pulse);

  assert_disabled_flag_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_lo != '1) |=> ((key_flags & ~$past(en_lo)) == '0));

  assert_combined_no_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_mode |=> (key_flags == '0));

  assert_pending_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> irq_pending);

  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !irq_pulse) |=> !irq_pending);
endmodule

bind key_irq_detect kirq_checker #(.NF(N_FLAGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_pulse  (irq_pulse),
  .irq_pending(irq_pending),
  .key_flags  (key_flags),
  .all_idle   (all_idle),
  .clr_q      (clr_q),
  .clr_write  (clr_write),
  .clr_bits   (clr_bits),
  .cfg_mode   (cfg_mode),
  .en_lo      (cfg_en[N_FLAGS-1:0]),
  .irq_ack    (irq_ack)
);

// File: tb/tb_key_irq_detect.sv
module tb_key_irq_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] keys = 10'h3FF;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [9:0] wr_data = '0;
  logic       irq_ack = 1'b0;
  logic       irq_pulse;
  logic       irq_pending;
  logic [5:0] key_flags;

  int checks = 0;
  int errors = 0;
  int pcount = 0;

  always #10 clk = ~clk;

  key_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .key_in(keys), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .irq_ack(irq_ack), .irq_pulse(irq_pulse),
    .irq_pending(irq_pending), .key_flags(key_flags)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [9:0] m_a, m_b, m_c;   // newest sample, synced level, previous level
  logic [5:0] m_flag;
  logic [9:0] m_en;
  logic       m_rise, m_mode, m_idle_prev, m_after_clr, m_pulse, m_pend;
  logic       t_idle, t_act, t_hold, t_edge, t_clr;
  logic [5:0] t_nf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_a = '1; m_b = '1; m_c = '1; m_flag = '0; m_en = '0;
      m_rise = 0; m_mode = 0; m_idle_prev = 1; m_after_clr = 0; m_pulse = 0; m_pend = 0;
    end else begin
      t_idle = 1;
      for (int i = 0; i < 10; i++) begin
        t_act  = m_rise ? m_b[i] : !m_b[i];
        t_hold = (i < 6 && m_mode) ? m_flag[i] : t_act;
        if (m_en[i] && t_hold) t_idle = 0;
      end
      for (int i = 0; i < 6; i++) begin
        t_edge  = m_rise ? (m_b[i] && !m_c[i]) : (!m_b[i] && m_c[i]);
        t_clr   = wr_en && wr_addr == 2'd2 && wr_data[i];
        t_nf[i] = m_mode && m_en[i] && !t_clr && (m_flag[i] || t_edge);
      end
      m_pend      = m_pulse || (m_pend && !(irq_ack || (wr_en && wr_addr == 2'd3)));
      m_pulse     = !t_idle && (m_idle_prev || m_after_clr);
      m_after_clr = wr_en && wr_addr == 2'd2 && m_mode;
      m_idle_prev = t_idle;
      m_flag      = t_nf;
      if (wr_en && wr_addr == 2'd0) begin m_rise = wr_data[0]; m_mode = wr_data[1]; end
      if (wr_en && wr_addr == 2'd1) m_en = wr_data;
      m_c = m_b; m_b = m_a; m_a = keys;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 model pulse", irq_pulse, m_pulse);
      chk("R10 model pending", irq_pending, m_pend);
      chk("R4 model flags", key_flags, m_flag);
      if (irq_pulse) pcount++;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset pulse", irq_pulse, 0);
    chk("R1 reset pending", irq_pending, 0);
    chk("R1 reset flags", key_flags, 0);

    // all lines disabled after reset
    keys[0] = 0; idle(6);
    chk("R8 R1 disabled line gives no pulse", pcount, 0);
    keys[0] = 1; idle(5);

    // R11: enable all, falling edge, combined mode
    wr(2'd1, 10'h3FF); wr(2'd0, 10'h000); idle(4);
    pcount = 0;
    keys[0] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 pulse on third edge", irq_pulse, 1);
    @(negedge clk);
    chk("R3 pulse one cycle wide", irq_pulse, 0);
    chk("R10 pending after pulse", irq_pending, 1);
    keys[1] = 0; idle(6);
    keys = 10'h3FF; idle(6);
    chk("R3 single pulse while busy", pcount, 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R10 ack clears pending", irq_pending, 0);
    keys[7] = 0; idle(6); keys[7] = 1; idle(5);
    chk("R10 pending again", irq_pending, 1);
    wr(2'd3, 10'h000);
    chk("R10 write clears pending", irq_pending, 0);

    // R2 rising edges
    wr(2'd1, 10'h000); keys = 10'h000; idle(5);
    wr(2'd0, 10'h001); wr(2'd1, 10'h3FF); idle(5);
    pcount = 0;
    keys[3] = 1; idle(6);
    chk("R2 R11 rising edge pulse", pcount, 1);
    keys[3] = 0; idle(6);
    chk("R2 falling ignored in rising mode", pcount, 1);

    // flag mode, falling edges
    wr(2'd1, 10'h000); keys = 10'h3FF; idle(5);
    wr(2'd0, 10'h002); wr(2'd1, 10'h3FF); wr(2'd3, 10'h000); idle(5);
    pcount = 0;
    keys[0] = 0; idle(6); keys[0] = 1; idle(6);
    chk("R4 flag0 held", key_flags, 1);
    chk("R4 first pulse", pcount, 1);
    keys[1] = 0; idle(6); keys[1] = 1; idle(6);
    chk("R4 flag1 set", key_flags, 3);
    chk("R4 no second pulse", pcount, 1);
    keys[6] = 0; idle(6); keys[6] = 1; idle(6);
    chk("R7 unflagged short press lost", pcount, 1);
    wr(2'd2, 10'h001);
    chk("R6 no pulse in clear cycle", irq_pulse, 0);
    @(negedge clk);
    chk("R6 pulse one clock after clear", irq_pulse, 1);
    idle(3);
    chk("R5 flag0 cleared only", key_flags, 2);
    wr(2'd2, 10'h002); idle(4);
    chk("R6 no pulse when idle after clear", pcount, 2);
    chk("R5 all flags cleared", key_flags, 0);

    // R5 clear and setting edge in the same cycle
    keys[2] = 0;
    @(negedge clk); @(negedge clk);
    wr(2'd2, 10'h004); idle(4);
    chk("R5 clear wins over same-cycle edge", key_flags, 0);
    chk("R5 no pulse", pcount, 2);
    keys[2] = 1; idle(5);

    // R8 enable mask
    wr(2'd1, 10'h3EF);
    keys[4] = 0; idle(6);
    chk("R8 disabled line sets no flag", key_flags, 0);
    chk("R8 disabled line no pulse", pcount, 2);
    keys[4] = 1; idle(5);
    keys[3] = 0; idle(6); keys[3] = 1; idle(5);
    chk("R8 flag3 set", key_flags, 8);
    wr(2'd1, 10'h3F7); idle(2);
    chk("R8 disable forces flag low", key_flags, 0);

    // R9 combined mode keeps flags at zero
    wr(2'd1, 10'h3FF); wr(2'd0, 10'h000); idle(4);
    pcount = 0;
    keys[5] = 0; idle(6);
    chk("R9 flags zero in combined mode", key_flags, 0);
    chk("R9 combined pulse", pcount, 1);
    keys[5] = 1; idle(6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 100000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule